// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit with Register File

This block supplies the two source operands of the execute stage of a five-stage in-order pipeline (fetch, execute, memory, align, writeback). It holds a register file with two combinational read ports and one write port. Both source operands are read at the start of the execute stage. Results reach the register file only in writeback, so an instruction in execute can depend on any of the three instructions ahead of it. Those three stages have not yet written the file, and forwarding must cover them.

Two of those producers are covered by multiplexers in front of each operand. Each multiplexer picks the result of the memory-stage instruction or of the align-stage instruction when the destination register number matches the source register number. The third producer, the writeback instruction, is covered inside the register file. A write in the current cycle is passed straight to any read port that addresses the same register, so no writeback-to-execute path is needed. Load-use stalls and the ALU are outside this block.

Top module: `opfwd_top`

## Requirements
- R1: Register 0 reads as zero on both operands in every case, including when a writeback, memory-stage or align-stage instruction names register 0 with its write enable high.
- R2: A writeback write (`w_we` high, `w_rd` non-zero) is stored at the rising clock edge and returned by later reads of that register when no younger producer matches.
- R3: In the cycle of a writeback write, a read port addressing the written non-zero register returns `w_data` instead of the stored value.
- R4: When `m_we` is high and `m_rd` equals a non-zero source register number, that operand equals `m_data`.
- R5: When `a_we` is high, `a_rd` equals a non-zero source register number and the memory stage does not match, that operand equals `a_data`.
- R6: When the memory and align stages both match a source register, the memory-stage result wins. When either of them matches, it wins over a same-cycle writeback write to that register.
- R7: A producer whose destination is register 0 is never forwarded. The operand stays zero.
- R8: A producer whose write enable is low is never forwarded, even when its register number matches. The operand then comes from the register file.
- R9: After reset every register reads as zero.
- R10: The two operands are resolved independently. Each can take a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the register file |
| w_we | input | 1 | Writeback-stage write enable |
| w_rd | input | AW (5) | Writeback-stage destination register |
| w_data | input | XLEN (32) | Writeback-stage result |
| e_rs | input | AW (5) | Execute-stage first source register number |
| e_rt | input | AW (5) | Execute-stage second source register number |
| m_we | input | 1 | Memory-stage write enable |
| m_rd | input | AW (5) | Memory-stage destination register |
| m_data | input | XLEN (32) | Memory-stage result |
| a_we | input | 1 | Align-stage write enable |
| a_rd | input | AW (5) | Align-stage destination register |
| a_data | input | XLEN (32) | Align-stage result |
| e_opa | output | XLEN (32) | Resolved first operand |
| e_opb | output | XLEN (32) | Resolved second operand |

## Verification
The bench targets four corner cases.

- **Priority order:** all three producers name the same register in one cycle. A design with a reversed order would hand execute a stale, older value.
- **Register 0:** a producer names register 0 with its write enable high. A design that forgets the zero check would leak a non-zero value into an operand that must read zero.
- **Write enable low:** the register number matches but the write enable is low. A design that ignores the enable would forward a result that was never meant to be written.
- **Same-cycle writeback:** a read hits the register being written. A file without write-through would return the previous contents for one cycle.

A long pseudo-random sweep then draws destination numbers mostly from the two live source registers, so that every mix of matches occurs on both ports at once.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
   typedef enum logic [1:0] {
      SRC_RF = 2'd0,
      SRC_A  = 2'd1,
      SRC_M  = 2'd2
   } fwd_src_e;
endpackage

// File: rtl/opfwd_regfile.sv
module opfwd_regfile #(
   parameter int XLEN          = 32,
   parameter int NREG          = 32,
   parameter int NRD           = 2,
   parameter bit WRITE_THROUGH = 1'b1,
   localparam int AW           = $clog2(NREG)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            wa,
   input  logic [XLEN-1:0]          wd,
   input  logic [NRD-1:0][AW-1:0]   ra,
   output logic [NRD-1:0][XLEN-1:0] rd
);
   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("opfwd_regfile: NREG must be a power of two >= 2");
   end
   if (XLEN < 1 || NRD < 1) begin : g_bad_width
      $error("opfwd_regfile: XLEN and NRD must be positive");
   end

   logic [XLEN-1:0] mem [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we && wa != '0) begin
         mem[wa] <= wd;
      end
   end

   AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      mem[0] == '0); // R1
   AST_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa != '0) |=> mem[$past(wa)] == $past(wd)); // R2

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic [XLEN-1:0] arr;
      assign arr = mem[ra[p]];
      if (WRITE_THROUGH) begin : g_wt
         assign rd[p] = (ra[p] == '0)             ? '0 :
                        (we && wa == ra[p])       ? wd : arr;
         AST_WT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wa != '0 && wa == ra[p]) |-> rd[p] == wd); // R3
      end else begin : g_plain
         assign rd[p] = (ra[p] == '0) ? '0 : arr;
      end
   end
endmodule

// File: rtl/opfwd_pick.sv
module opfwd_pick
   import opfwd_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] src,
   input  logic          m_we,
   input  logic [AW-1:0] m_rd,
   input  logic          a_we,
   input  logic [AW-1:0] a_rd,
   output fwd_src_e      sel
);
   logic src_live, m_hit, a_hit;

   assign src_live = (src != '0);
   assign m_hit    = src_live && m_we && (m_rd == src);
   assign a_hit    = src_live && a_we && (a_rd == src);

   always_comb begin
      if (m_hit)      sel = SRC_M;
      else if (a_hit) sel = SRC_A;
      else            sel = SRC_RF;
   end

   AST_R0_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
      (src == '0) |-> sel == SRC_RF); // R7
   AST_WE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_we && !a_we) |-> sel == SRC_RF); // R8
   AST_YOUNG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (m_we && a_we && m_rd == src && a_rd == src && src != '0) |-> sel == SRC_M); // R6
endmodule

// File: rtl/opfwd_top.sv
module opfwd_top
   import opfwd_pkg::*;
#(
   parameter int  XLEN = 32,
   parameter int  NREG = 32,
   localparam int AW   = $clog2(NREG),
   localparam int NOPS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            w_we,
   input  logic [AW-1:0]   w_rd,
   input  logic [XLEN-1:0] w_data,
   input  logic [AW-1:0]   e_rs,
   input  logic [AW-1:0]   e_rt,
   input  logic            m_we,
   input  logic [AW-1:0]   m_rd,
   input  logic [XLEN-1:0] m_data,
   input  logic            a_we,
   input  logic [AW-1:0]   a_rd,
   input  logic [XLEN-1:0] a_data,
   output logic [XLEN-1:0] e_opa,
   output logic [XLEN-1:0] e_opb
);
   logic [NOPS-1:0][AW-1:0]   src_num;
   logic [NOPS-1:0][XLEN-1:0] rf_val;
   logic [NOPS-1:0][XLEN-1:0] opnd;

   assign src_num[0] = e_rs;
   assign src_num[1] = e_rt;

   opfwd_regfile #(
      .XLEN(XLEN), .NREG(NREG), .NRD(NOPS), .WRITE_THROUGH(1'b1)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(w_we), .wa(w_rd), .wd(w_data),
      .ra(src_num), .rd(rf_val)
   );

   for (genvar k = 0; k < NOPS; k++) begin : g_op
      fwd_src_e sel;
      opfwd_pick #(.AW(AW)) u_pick (
         .clk(clk), .rst_n(rst_n), .src(src_num[k]),
         .m_we(m_we), .m_rd(m_rd), .a_we(a_we), .a_rd(a_rd),
         .sel(sel)
      );
      assign opnd[k] = (sel == SRC_M) ? m_data :
                       (sel == SRC_A) ? a_data : rf_val[k];
   end

   assign e_opa = opnd[0];
   assign e_opb = opnd[1];

   AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (e_rs == '0) |-> e_opa == '0); // R1
   AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (e_rt == '0) |-> e_opb == '0); // R1
   AST_MFWD_A: assert property (@(posedge clk) disable iff (!rst_n)
      (m_we && m_rd == e_rs && e_rs != '0) |-> e_opa == m_data); // R4
   AST_MFWD_B: assert property (@(posedge clk) disable iff (!rst_n)
      (m_we && m_rd == e_rt && e_rt != '0) |-> e_opb == m_data); // R4
   AST_AFWD_A: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we && a_rd == e_rs && e_rs != '0 && !(m_we && m_rd == e_rs)) |-> e_opa == a_data); // R5
   AST_AFWD_B: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we && a_rd == e_rt && e_rt != '0 && !(m_we && m_rd == e_rt)) |-> e_opb == a_data); // R5
endmodule

// File: tb/opfwd_top_tb_top.sv
`timescale 1ns/1ps
module opfwd_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        w_we = 1'b0, m_we = 1'b0, a_we = 1'b0;
   logic [4:0]  w_rd = '0, m_rd = '0, a_rd = '0, e_rs = '0, e_rt = '0;
   logic [31:0] w_data = '0, m_data = '0, a_data = '0;
   logic [31:0] e_opa, e_opb;

   logic [31:0] shadow [32];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   opfwd_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .w_we(w_we), .w_rd(w_rd), .w_data(w_data),
      .e_rs(e_rs), .e_rt(e_rt),
      .m_we(m_we), .m_rd(m_rd), .m_data(m_data),
      .a_we(a_we), .a_rd(a_rd), .a_data(a_data),
      .e_opa(e_opa), .e_opb(e_opb)
   );

   // Reference: M beats A beats same-cycle W beats stored value; reg 0 is zero.
   function automatic logic [31:0] model(input logic [4:0] s, output string tag);
      if (s == 0)                    begin tag = "R1"; return 32'h0; end
      if (m_we && m_rd == s)         begin tag = (a_we && a_rd == s) ? "R6" : "R4"; return m_data; end
      if (a_we && a_rd == s)         begin tag = (w_we && w_rd == s) ? "R6" : "R5"; return a_data; end
      if (w_we && w_rd == s)         begin tag = "R3"; return w_data; end
      tag = ((m_rd == s) || (a_rd == s)) ? "R8" : "R2";
      return shadow[s];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic check_both();
      string ta, tb;
      logic [31:0] ea, eb;
      #1;
      ea = model(e_rs, ta);
      eb = model(e_rt, tb);
      chk({ta, " opa R10"}, e_opa, ea);
      chk({tb, " opb R10"}, e_opb, eb);
   endtask

   task automatic tick();
      @(posedge clk);
      if (w_we && w_rd != 0) shadow[w_rd] = w_data;
      @(negedge clk);
   endtask

   task automatic idle();
      w_we = 0; m_we = 0; a_we = 0;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: every register is zero after reset
      for (int r = 0; r < 32; r++) begin
         e_rs = r[4:0]; e_rt = 5'(31 - r); #1;
         chk("R9 opa", e_opa, 32'h0);
         chk("R9 opb", e_opb, 32'h0);
      end

      // R2/R3: fill all registers; rs reads the one being written, rt an older one
      for (int r = 0; r < 32; r++) begin
         w_we = 1; w_rd = r[4:0]; w_data = 32'hA500_0000 + 32'(r * 32'h0101);
         e_rs = r[4:0]; e_rt = 5'((r + 31) % 32);
         check_both();
         tick();
      end
      idle();
      for (int r = 0; r < 32; r++) begin
         e_rs = r[4:0]; e_rt = 5'(31 - r); #1;
         chk("R2 opa", e_opa, (r == 0) ? 32'h0 : 32'hA500_0000 + 32'(r * 32'h0101));
         chk("R1 R2 opb", e_opb, shadow[31 - r]);
      end

      // R6: all three producers on the same register, then drop M, then drop A
      e_rs = 5'd7; e_rt = 5'd7;
      m_we = 1; m_rd = 5'd7; m_data = 32'h1111_1111;
      a_we = 1; a_rd = 5'd7; a_data = 32'h2222_2222;
      w_we = 1; w_rd = 5'd7; w_data = 32'h3333_3333; #1;
      chk("R6 M first", e_opa, 32'h1111_1111);
      m_we = 0; #1;
      chk("R6 A over W", e_opa, 32'h2222_2222);
      a_we = 0; #1;
      chk("R3 W pass", e_opb, 32'h3333_3333);
      tick();
      idle();

      // R7: producers aim at register 0 with enables high
      e_rs = 5'd0; e_rt = 5'd0;
      m_we = 1; m_rd = 5'd0; m_data = 32'hDEAD_BEEF;
      a_we = 1; a_rd = 5'd0; a_data = 32'hCAFE_F00D;
      w_we = 1; w_rd = 5'd0; w_data = 32'h0BAD_0BAD; #1;
      chk("R7 opa", e_opa, 32'h0);
      chk("R7 opb", e_opb, 32'h0);
      tick();
      idle(); #1;
      chk("R1 after write", e_opa, 32'h0);

      // R8: matching numbers, enables low
      e_rs = 5'd9; e_rt = 5'd10;
      m_rd = 5'd9; m_data = 32'h5555_5555;
      a_rd = 5'd10; a_data = 32'h6666_6666; #1;
      chk("R8 opa", e_opa, shadow[9]);
      chk("R8 opb", e_opb, shadow[10]);

      // R10: different sources on the two ports
      m_we = 1; a_we = 1; #1;
      chk("R10 R4 opa", e_opa, 32'h5555_5555);
      chk("R10 R5 opb", e_opb, 32'h6666_6666);
      idle();

      // Pseudo-random sweep biased toward matches
      for (int it = 0; it < 3000; it++) begin
         logic [31:0] rv;
         rv = $urandom;
         e_rs = rv[4:0]; e_rt = rv[9:5];
         m_we = rv[10]; a_we = rv[11]; w_we = rv[12];
         m_rd = rv[14] ? (rv[13] ? e_rs : e_rt) : rv[19:15];
         a_rd = rv[21] ? (rv[20] ? e_rs : e_rt) : rv[26:22];
         w_rd = rv[28] ? (rv[27] ? e_rs : e_rt) : 5'($urandom);
         m_data = $urandom; a_data = $urandom; w_data = $urandom;
         check_both();
         tick();
      end
      idle();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule